// File: doc/BRIEF.md
# Seven-Segment VGA Display Emulator

This block drives a 640x480, 60 Hz VGA monitor from a 25 MHz pixel clock. It draws a single row of large seven-segment digits, so the monitor can stand in for a physical seven-segment display. A horizontal pixel counter and a vertical line counter generate the two sync pulses and the blank signal. The same counters give the raster position from which every digit is drawn.

Each digit field takes an 8-bit code. The code holds either a decimal digit or a raw segment pattern, so operator symbols can be shown in the same row. A sign cell sits directly in front of the result digits, which are the last fields of the row. When the sign input is set, that cell shows a minus bar. When the overflow input is set, the sign cell and the result digits are drawn in red.

All cells share one segment-drawing engine. Each cell only finds out whether the current pixel falls inside it. The selected cell's local coordinates and segment pattern then go to that single engine.

Top module: `segvga_top`

## Requirements
- R1: A line lasts H_TOT = 800 pixel clocks, of which the first 640 are visible. The active-low horizontal sync is 0 exactly for pixel counts 656 through 751.
- R2: A frame lasts V_TOT = 521 lines, of which the first 480 are visible. The active-low vertical sync is 0 exactly for lines 490 and 491. The line count advances when the pixel count wraps from 799 to 0.
- R3: `blank` is 1 when the pixel count is 640 or more, or the line count is 480 or more. `rgb` is 000 whenever `blank` is 1.
- R4: Reset is synchronous and active high. During reset both counters hold 0 and the outputs read hsyncN=1, vsyncN=1, blank=1, rgb=000. All outputs are registered, so the first clock after reset is released presents pixel (0,0). Each later clock presents the next raster position.
- R5: The row has NUM_DIGITS+1 cells. Each cell is 48x80 pixels. Cell c spans x from X0+56c to X0+56c+47 and y from Y0 to Y0+79. Fields 0 to SIGN_CELL-1 map to cells of the same index, where SIGN_CELL = NUM_DIGITS-RES_DIGITS. Cell SIGN_CELL is the sign cell. Field f ≥ SIGN_CELL maps to cell f+1.
- R6: Segments are 6 pixels thick in cell-local coordinates (lx,ly). The three bars a (top), g (middle) and d (bottom) span lx 6..41, at ly 0..5, 37..42 and 74..79 respectively. The left segments f and e sit at lx 0..5, and the right segments b and c sit at lx 42..47. The upper ones (f, b) cover ly 6..36 and the lower ones (e, c) cover ly 43..73. Corner pixels are never lit.
- R7: In a field code, bit 7 = 1 means bits 6:0 are a raw segment pattern, with bit 0 = a through bit 6 = g. Bit 7 = 0 means bits 3:0 are a decimal digit drawn in the usual seven-segment shapes for 0–9. Values 10–15 draw nothing.
- R8: The sign cell lights only segment g when `signNeg` is 1, and lights nothing when it is 0.
- R9: `rgb` is {red, green, blue}. A lit segment pixel is 111. Any other visible pixel is 000.
- R10: When `overflow` is 1, lit pixels of the sign cell and the result cells are 100 (red). Lit pixels of the other cells stay 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| digits | input | NUM_DIGITS*8 | Field codes, field f in bits 8f+7..8f |
| signNeg | input | 1 | Show a minus bar in the sign cell |
| overflow | input | 1 | Draw sign and result cells in red |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible area |
| rgb | output | 3 | Pixel colour {r,g,b} |

## Verification
The assertions assume the parameters describe a valid raster. Both sync windows must lie inside the blanking interval, and the row of cells must fit inside the visible area. Given that, every sync pulse falls where blank is high, and only the three colours 000, 111 and 100 can appear. The bench keeps the default horizontal timing and uses a shortened frame of 130 lines, with vertical sync at lines 110–111 and the row at Y0=10. That keeps both assumptions true and lets a whole frame fit in the run. Field codes and the sign and overflow inputs change only between probes, never while the pixel under test is being produced.

// File: rtl/segvga_pkg.sv
package segvga_pkg;

  localparam int CELL_W     = 48;
  localparam int CELL_H     = 80;
  localparam int SEG_T      = 6;
  localparam int CELL_PITCH = 56;
  localparam int MID_Y      = CELL_H / 2 - SEG_T / 2;

  typedef struct packed {
    logic hVis;
    logic vVis;
    logic hSync;
    logic vSync;
  } rasterCtl_t;

  // Field code to segment pattern, bit 0 = a ... bit 6 = g.
  function automatic logic [6:0] codeToSeg(input logic [7:0] code);
    logic [6:0] seg;
    if (code[7]) begin
      seg = code[6:0];
    end else begin
      case (code[3:0])
        4'd0:    seg = 7'h3F;
        4'd1:    seg = 7'h06;
        4'd2:    seg = 7'h5B;
        4'd3:    seg = 7'h4F;
        4'd4:    seg = 7'h66;
        4'd5:    seg = 7'h6D;
        4'd6:    seg = 7'h7D;
        4'd7:    seg = 7'h07;
        4'd8:    seg = 7'h7F;
        4'd9:    seg = 7'h6F;
        default: seg = 7'h00;
      endcase
    end
    return seg;
  endfunction

  // Shared segment engine: is local pixel (lx,ly) on a lit segment.
  function automatic logic segLit(input logic [5:0] lx, input logic [6:0] ly,
                                  input logic [6:0] seg);
    int x;
    int y;
    logic midSpan;
    logic leftCol;
    logic rightCol;
    logic upper;
    logic lower;
    x        = int'(lx);
    y        = int'(ly);
    midSpan  = (x >= SEG_T) && (x < CELL_W - SEG_T);
    leftCol  = (x < SEG_T);
    rightCol = (x >= CELL_W - SEG_T) && (x < CELL_W);
    upper    = (y >= SEG_T) && (y < MID_Y);
    lower    = (y >= MID_Y + SEG_T) && (y < CELL_H - SEG_T);
    return (seg[0] && midSpan && (y < SEG_T))
        || (seg[1] && rightCol && upper)
        || (seg[2] && rightCol && lower)
        || (seg[3] && midSpan && (y >= CELL_H - SEG_T) && (y < CELL_H))
        || (seg[4] && leftCol && lower)
        || (seg[5] && leftCol && upper)
        || (seg[6] && midSpan && (y >= MID_Y) && (y < MID_Y + SEG_T));
  endfunction

endpackage

// File: rtl/segvga_timing.sv
module segvga_timing
  import segvga_pkg::*;
#(
  parameter int H_VIS = 640,
  parameter int H_SS  = 656,
  parameter int H_SE  = 752,
  parameter int H_TOT = 800,
  parameter int V_VIS = 480,
  parameter int V_SS  = 490,
  parameter int V_SE  = 492,
  parameter int V_TOT = 521,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] hCnt,
  output logic [CNT_W-1:0] vCnt,
  output rasterCtl_t       ctl
);

  localparam logic [CNT_W-1:0] H_LAST = CNT_W'(H_TOT - 1);
  localparam logic [CNT_W-1:0] V_LAST = CNT_W'(V_TOT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (hCnt == H_LAST) begin
      hCnt <= '0;
      vCnt <= (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.hVis  = hCnt < CNT_W'(H_VIS);
    ctl.vVis  = vCnt < CNT_W'(V_VIS);
    ctl.hSync = (hCnt >= CNT_W'(H_SS)) && (hCnt < CNT_W'(H_SE));
    ctl.vSync = (vCnt >= CNT_W'(V_SS)) && (vCnt < CNT_W'(V_SE));
  end

  // R1: the pixel count returns to zero after the last clock of a line
  a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
    hCnt == H_LAST |=> hCnt == '0);

  // R2: the line count steps by one at each line wrap inside a frame
  a_r2_line_step: assert property (@(posedge clk) disable iff (rst)
    (hCnt == H_LAST && vCnt != V_LAST) |=> vCnt == $past(vCnt) + CNT_W'(1));

endmodule

// File: rtl/segvga_pixel.sv
module segvga_pixel
  import segvga_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int X0         = 64,
  parameter int Y0         = 200,
  parameter int NUM_DIGITS = 7,
  parameter int RES_DIGITS = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W-1:0]        hCnt,
  input  logic [CNT_W-1:0]        vCnt,
  input  rasterCtl_t              ctl,
  input  logic [NUM_DIGITS*8-1:0] digits,
  input  logic                    signNeg,
  input  logic                    overflow,
  output logic                    hsyncN,
  output logic                    vsyncN,
  output logic                    blank,
  output logic [2:0]              rgb
);

  localparam int NCELLS    = NUM_DIGITS + 1;
  localparam int SIGN_CELL = NUM_DIGITS - RES_DIGITS;

  logic [NCELLS-1:0] hitC;
  logic [NCELLS-1:0] resC;
  logic [5:0]        lxC  [NCELLS];
  logic [6:0]        patC [NCELLS];

  for (genvar c = 0; c < NCELLS; c++) begin : g_cell
    localparam int BASE = X0 + c * CELL_PITCH;
    assign hitC[c] = (hCnt >= CNT_W'(BASE)) && (hCnt < CNT_W'(BASE + CELL_W));
    assign lxC[c]  = 6'(hCnt - CNT_W'(BASE));
    assign resC[c] = (c >= SIGN_CELL);
    if (c < SIGN_CELL) begin : g_lead
      assign patC[c] = codeToSeg(digits[8*c +: 8]);
    end else if (c == SIGN_CELL) begin : g_sign
      assign patC[c] = signNeg ? 7'h40 : 7'h00;
    end else begin : g_res
      assign patC[c] = codeToSeg(digits[8*(c-1) +: 8]);
    end
  end

  logic [5:0] selLx;
  logic [6:0] selPat;
  logic       selRes;
  logic       rowHit;
  logic [6:0] ly;
  logic       lit;
  logic       blankNext;

  always_comb begin
    selLx  = '0;
    selPat = '0;
    selRes = 1'b0;
    for (int c = 0; c < NCELLS; c++) begin
      if (hitC[c]) begin
        selLx  = lxC[c];
        selPat = patC[c];
        selRes = resC[c];
      end
    end
  end

  assign rowHit    = (vCnt >= CNT_W'(Y0)) && (vCnt < CNT_W'(Y0 + CELL_H));
  assign ly        = 7'(vCnt - CNT_W'(Y0));
  assign lit       = rowHit && (|hitC) && segLit(selLx, ly, selPat);
  assign blankNext = !(ctl.hVis && ctl.vVis);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncN <= 1'b1;
      vsyncN <= 1'b1;
      blank  <= 1'b1;
      rgb    <= 3'b000;
    end else begin
      hsyncN <= !ctl.hSync;
      vsyncN <= !ctl.vSync;
      blank  <= blankNext;
      if (blankNext || !lit)          rgb <= 3'b000;
      else if (overflow && selRes)    rgb <= 3'b100;
      else                            rgb <= 3'b111;
    end
  end

  // R3: a horizontal sync pulse only occurs in blanking
  a_r3_hsync_in_blank: assert property (@(posedge clk) disable iff (rst)
    !hsyncN |-> blank);

  // R2: a vertical sync pulse only occurs in blanking
  a_r2_vsync_in_blank: assert property (@(posedge clk) disable iff (rst)
    !vsyncN |-> blank);

  // R9 and R10: only black, white or red reach the pins
  a_r9_palette: assert property (@(posedge clk) disable iff (rst)
    (rgb == 3'b000) || (rgb == 3'b111) || (rgb == 3'b100));

endmodule

// File: rtl/segvga_top.sv
module segvga_top #(
  parameter int H_VIS      = 640,
  parameter int H_SS       = 656,
  parameter int H_SE       = 752,
  parameter int H_TOT      = 800,
  parameter int V_VIS      = 480,
  parameter int V_SS       = 490,
  parameter int V_SE       = 492,
  parameter int V_TOT      = 521,
  parameter int X0         = 64,
  parameter int Y0         = 200,
  parameter int NUM_DIGITS = 7,
  parameter int RES_DIGITS = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_DIGITS*8-1:0] digits,
  input  logic                    signNeg,
  input  logic                    overflow,
  output logic                    hsyncN,
  output logic                    vsyncN,
  output logic                    blank,
  output logic [2:0]              rgb
);

  localparam int CNT_W = $clog2((H_TOT > V_TOT) ? H_TOT : V_TOT);

  logic [CNT_W-1:0]      hCnt;
  logic [CNT_W-1:0]      vCnt;
  segvga_pkg::rasterCtl_t ctl;

  segvga_timing #(
    .H_VIS(H_VIS), .H_SS(H_SS), .H_SE(H_SE), .H_TOT(H_TOT),
    .V_VIS(V_VIS), .V_SS(V_SS), .V_SE(V_SE), .V_TOT(V_TOT),
    .CNT_W(CNT_W)
  ) u_timing (
    .clk(clk), .rst(rst), .hCnt(hCnt), .vCnt(vCnt), .ctl(ctl)
  );

  segvga_pixel #(
    .CNT_W(CNT_W), .X0(X0), .Y0(Y0),
    .NUM_DIGITS(NUM_DIGITS), .RES_DIGITS(RES_DIGITS)
  ) u_pixel (
    .clk(clk), .rst(rst), .hCnt(hCnt), .vCnt(vCnt), .ctl(ctl),
    .digits(digits), .signNeg(signNeg), .overflow(overflow),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .blank(blank), .rgb(rgb)
  );

endmodule

// File: tb/segvga_top_test.sv
`timescale 1ns/1ps
module segvga_top_test;

  localparam int HT = 800, HV = 640, HS0 = 656, HS1 = 752;
  localparam int VT = 130, VV = 100, VS0 = 110, VS1 = 112;
  localparam int ND = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ND*8-1:0] digits;
  logic signNeg, overflow;
  logic hsyncN, vsyncN, blank;
  logic [2:0] rgb;

  int checks = 0;
  int fails  = 0;
  int mh = 0, mv = 0;
  logic mvalid = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  segvga_top #(
    .H_VIS(HV), .H_SS(HS0), .H_SE(HS1), .H_TOT(HT),
    .V_VIS(VV), .V_SS(VS0), .V_SE(VS1), .V_TOT(VT),
    .X0(64), .Y0(10), .NUM_DIGITS(ND), .RES_DIGITS(3)
  ) uut (
    .clk(clk), .rst(rst), .digits(digits), .signNeg(signNeg),
    .overflow(overflow), .hsyncN(hsyncN), .vsyncN(vsyncN),
    .blank(blank), .rgb(rgb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at (%0d,%0d): actual %0d expected %0d", req, mh, mv, act, exp);
    end
  endtask

  // Raster position presented at the outputs (R4: one register stage)
  always @(posedge clk) begin
    if (rst) mvalid <= 1'b0;
    else if (!mvalid) begin
      mvalid <= 1'b1; mh <= 0; mv <= 0;
    end else if (mh == HT - 1) begin
      mh <= 0;
      mv <= (mv == VT - 1) ? 0 : mv + 1;
    end else mh <= mh + 1;
  end

  // Continuous timing monitor
  always @(negedge clk) begin
    if (mvalid && !rst && !finished) begin
      chk("R1 hsync", int'(hsyncN), (mh >= HS0 && mh < HS1) ? 0 : 1);
      chk("R2 vsync", int'(vsyncN), (mv >= VS0 && mv < VS1) ? 0 : 1);
      chk("R3 blank", int'(blank), (mh >= HV || mv >= VV) ? 1 : 0);
      if (blank) chk("R3 dark in blank", int'(rgb), 0);
    end
  end

  task automatic waitPixel(input int x, input int y);
    do @(negedge clk); while (!(mvalid && mh == x && mv == y));
  endtask

  // x, y, expected rgb; fields: 8, raw g, 1, code 12, sign '-', 0, 7, 2
  localparam int TAB1 [0:22][0:2] = '{
    '{64, 12, 0},   // R6 corner unlit
    '{70, 12, 7},   // R6 first pixel of bar a
    '{84, 12, 7},   // R7 digit 8 top
    '{140, 12, 0},  // R7 raw pattern g only
    '{196, 12, 0},  // R7 digit 1 no top
    '{308, 12, 0},  // R8 sign cell top off
    '{364, 12, 7},  // R5 result field 4 in cell 5
    '{420, 12, 7},  // R7 digit 7 top
    '{108, 30, 7},  // R6 segment b
    '{178, 30, 0},  // R7 digit 1 no f
    '{220, 30, 7},  // R7 digit 1 b
    '{500, 30, 7},  // R5 last cell b
    '{84, 49, 7},   // R6 middle bar
    '{114, 49, 0},  // R5 gap between cells
    '{140, 49, 7},  // R7 raw pattern g
    '{252, 49, 0},  // R7 code 12 blank
    '{308, 49, 7},  // R8 minus bar
    '{364, 49, 0},  // R7 digit 0 no g
    '{458, 60, 7},  // R6 segment e of digit 2
    '{500, 60, 0},  // R7 digit 2 no c
    '{84, 86, 7},   // R6 bottom bar
    '{420, 86, 0},  // R7 digit 7 no d
    '{84, 95, 0}    // R5 below the row, R9 background
  };

  // with overflow=1, sign=0
  localparam int TAB2 [0:5][0:2] = '{
    '{84, 12, 7},   // R10 non-result cell stays white
    '{364, 12, 4},  // R10 result red
    '{420, 12, 4},  // R10 result red
    '{140, 49, 7},  // R10 operator stays white
    '{308, 49, 0},  // R8 positive sign draws nothing
    '{364, 49, 0}   // R9 background stays black
  };

  initial begin
    digits   = {8'h02, 8'h07, 8'h00, 8'h0C, 8'h01, 8'hC0, 8'h08};
    signNeg  = 1'b1;
    overflow = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 reset hsync", int'(hsyncN), 1);
    chk("R4 reset blank", int'(blank), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 first pixel visible", int'(blank), 0);
    chk("R4 first pixel position", mh, 0);

    for (int i = 0; i < 23; i++) begin
      waitPixel(TAB1[i][0], TAB1[i][1]);
      chk("R6/R7 pixel colour", int'(rgb), TAB1[i][2]);
    end

    overflow = 1'b1;
    signNeg  = 1'b0;
    for (int i = 0; i < 6; i++) begin
      waitPixel(TAB2[i][0], TAB2[i][1]);
      chk("R10 pixel colour", int'(rgb), TAB2[i][2]);
    end

    // R4: mid-frame reset
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 reset vsync", int'(vsyncN), 1);
    chk("R4 reset blank", int'(blank), 1);
    chk("R4 reset rgb", int'(rgb), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 restart at origin", mh + mv, 0);
    chk("R4 restart visible", int'(blank), 0);

    // R1 and R3 sync and blank edges
    waitPixel(639, 0); chk("R3 last visible", int'(blank), 0);
    waitPixel(640, 0); chk("R3 first blank", int'(blank), 1);
    waitPixel(655, 0); chk("R1 before sync", int'(hsyncN), 1);
    waitPixel(656, 0); chk("R1 sync start", int'(hsyncN), 0);
    waitPixel(751, 0); chk("R1 sync last", int'(hsyncN), 0);
    waitPixel(752, 0); chk("R1 sync end", int'(hsyncN), 1);
    waitPixel(0, 1);   chk("R2 next line", int'(blank), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #975000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule